// File: doc/BRIEF.md
# Transmit Jabber and Collision Supervisor

This block sits in one port of a 10 Mb/s twisted-pair front end and runs on the 10 MHz transmit clock. It watches the controller's transmit request and data. If the transmitter stays on for too long, it cuts the transmitter off from the line, raises a jabber flag, and holds the cut-off until the controller has been quiet for a much longer recovery window. In half duplex it raises a collision flag when the port transmits to the line while the receiver reports activity. It lowers that flag on the next change of the transmit request or when receive activity stops.

The block also chooses what the controller sees on its receive side. There are three sources:
- the port's own transmit data, echoed back during half-duplex transmission;
- transmit data turned around inside the port when port loopback is selected;
- the line receive data, in every other case.

Line coding, the analog driver and controller-side signal polarity are handled elsewhere. Both timing windows are parameter cycle counts. At 10 MHz the defaults give 100 ms and 420 ms. Simulation uses small values.

Top module: `txsup_port`

## Requirements
- R1: `line_tx_en` is high exactly when `tx_en` is high, `jabber` is low and `port_lb` is low. `line_tx_dat` equals `tx_dat` while `line_tx_en` is high and is 0 otherwise, so both line outputs are idle whenever `tx_en` is low.
- R2: `jabber` rises at the clock edge that samples `tx_en` high for the (JAB_LIMIT+1)-th consecutive time. A burst of exactly JAB_LIMIT cycles followed by `tx_en` low leaves `jabber` low.
- R3: While `jabber` is high, the line outputs stay idle whatever `tx_en` and `tx_dat` do.
- R4: While jabbering, a cycle counts as quiet when `tx_en` and `tx_dat` are both sampled low. `jabber` falls at the edge that samples the IDLE_LIMIT-th consecutive quiet cycle. Any non-quiet cycle restarts the count.
- R5: With `full_dup` low and `port_lb` low, a clock edge that samples `line_tx_en` and `rx_act` both high sets `coll` after that edge.
- R6: A set `coll` clears at the first edge where `tx_en` differs from its value at the previous edge, or where `rx_act` is sampled low after being sampled high.
- R7: With `full_dup` high, `coll` is low after the next edge, and `rx_dat`/`crs` follow the line (`rx_line_dat` gated by `rx_act`, and `rx_act`). Transmit data is never echoed.
- R8: In half duplex without loopback, while `line_tx_en` is high, `crs` is 1 and `rx_dat` equals `tx_dat`.
- R9: While `jabber` is high, the echo is suppressed: `rx_dat`/`crs` follow the line.
- R10: With `port_lb` high, `crs` equals `tx_en` and `rx_dat` equals `tx_dat` while `tx_en` is high (0 otherwise). Line receive inputs are ignored, the line transmitter is idle, and `coll` is low after the next edge.
- R11: After reset with all inputs low, `jabber`, `coll`, `line_tx_en`, `line_tx_dat`, `rx_dat` and `crs` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Controller transmit request |
| tx_dat | input | 1 | Controller NRZ transmit data |
| rx_act | input | 1 | Line receive activity |
| rx_line_dat | input | 1 | Decoded line receive data |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| port_lb | input | 1 | Port loopback select |
| line_tx_en | output | 1 | Gated transmit enable toward the line |
| line_tx_dat | output | 1 | Gated transmit data toward the line |
| jabber | output | 1 | Jabber cut-off status |
| coll | output | 1 | Collision status |
| rx_dat | output | 1 | Receive data to the controller |
| crs | output | 1 | Carrier detect to the controller |

## Verification
A wrong shared counter value shows up at `jabber`. The flag either rises one or more cycles off the (JAB_LIMIT+1)-th edge or releases before the quiet window completes. The bench therefore checks the flag on every cycle around both boundaries. A stale transmit-enable or receive-activity history register shows up as `coll` failing to drop at the first edge after a toggle or after receive activity ends. That error is visible one cycle after the causing input. A wrong source choice is visible in the same cycle at `rx_dat`/`crs`. The bench drives transmit and line data with opposite values so that any misrouting differs at the port.

// File: rtl/txsup_pkg.sv
package txsup_pkg;
  typedef enum logic [1:0] {
    SRC_LINE = 2'd0,
    SRC_ECHO = 2'd1,
    SRC_LOOP = 2'd2
  } rx_src_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/txsup_jabber.sv
module txsup_jabber #(
  parameter int unsigned JAB_LIMIT  = 1_000_000,
  parameter int unsigned IDLE_LIMIT = 4_200_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_dat,
  output logic jab_o
);
  localparam int unsigned MAXV = txsup_pkg::max_u(JAB_LIMIT, IDLE_LIMIT);
  localparam int unsigned CW   = $clog2(MAXV + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          jab_q, jab_d;
  logic          quiet, upd_en;

  assign quiet  = !tx_en && !tx_dat;
  assign upd_en = jab_q || tx_en || (cnt_q != '0);

  // one counter serves both windows: run length while armed, quiet length while cut off
  always_comb begin
    cnt_d = cnt_q;
    jab_d = jab_q;
    if (!jab_q) begin
      if (tx_en) begin
        if (cnt_q == CW'(JAB_LIMIT)) begin
          jab_d = 1'b1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end else begin
      if (quiet) begin
        if (cnt_q == CW'(IDLE_LIMIT - 1)) begin
          jab_d = 1'b0;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      jab_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      jab_q <= jab_d;
    end
  end

  assign jab_o = jab_q;
endmodule

// File: rtl/txsup_collide.sv
module txsup_collide (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic rx_act,
  input  logic line_act,
  input  logic full_dup,
  input  logic port_lb,
  output logic coll_o
);
  logic tx_en_q, rx_act_q, coll_q, coll_d;
  logic tx_edge, rx_end;

  assign tx_edge = tx_en ^ tx_en_q;
  assign rx_end  = rx_act_q & ~rx_act;

  always_comb begin
    if (full_dup || port_lb)
      coll_d = 1'b0;
    else if (coll_q)
      coll_d = !(tx_edge || rx_end);
    else
      coll_d = line_act && rx_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q  <= 1'b0;
      rx_act_q <= 1'b0;
      coll_q   <= 1'b0;
    end else begin
      tx_en_q  <= tx_en;
      rx_act_q <= rx_act;
      coll_q   <= coll_d;
    end
  end

  assign coll_o = coll_q;
endmodule

// File: rtl/txsup_steer.sv
module txsup_steer
  import txsup_pkg::*;
(
  input  logic tx_en,
  input  logic tx_dat,
  input  logic rx_act,
  input  logic rx_line_dat,
  input  logic full_dup,
  input  logic port_lb,
  input  logic line_act,
  output logic rx_dat,
  output logic crs
);
  rx_src_e src;

  always_comb begin
    if (port_lb)
      src = SRC_LOOP;
    else if (!full_dup && line_act)
      src = SRC_ECHO;
    else
      src = SRC_LINE;
  end

  always_comb begin
    unique case (src)
      SRC_LOOP: begin
        crs    = tx_en;
        rx_dat = tx_en & tx_dat;
      end
      SRC_ECHO: begin
        crs    = 1'b1;
        rx_dat = tx_dat;
      end
      default: begin
        crs    = rx_act;
        rx_dat = rx_act & rx_line_dat;
      end
    endcase
  end
endmodule

// File: rtl/txsup_port.sv
module txsup_port #(
  parameter int unsigned JAB_LIMIT  = 1_000_000,
  parameter int unsigned IDLE_LIMIT = 4_200_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_dat,
  input  logic rx_act,
  input  logic rx_line_dat,
  input  logic full_dup,
  input  logic port_lb,
  output logic line_tx_en,
  output logic line_tx_dat,
  output logic jabber,
  output logic coll,
  output logic rx_dat,
  output logic crs
);
  logic jab_w, line_act;

  txsup_jabber #(
    .JAB_LIMIT (JAB_LIMIT),
    .IDLE_LIMIT(IDLE_LIMIT)
  ) u_jab (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_en (tx_en),
    .tx_dat(tx_dat),
    .jab_o (jab_w)
  );

  assign line_act    = tx_en & ~jab_w & ~port_lb;
  assign line_tx_en  = line_act;
  assign line_tx_dat = line_act & tx_dat;
  assign jabber      = jab_w;

  txsup_collide u_col (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .rx_act  (rx_act),
    .line_act(line_act),
    .full_dup(full_dup),
    .port_lb (port_lb),
    .coll_o  (coll)
  );

  txsup_steer u_steer (
    .tx_en      (tx_en),
    .tx_dat     (tx_dat),
    .rx_act     (rx_act),
    .rx_line_dat(rx_line_dat),
    .full_dup   (full_dup),
    .port_lb    (port_lb),
    .line_act   (line_act),
    .rx_dat     (rx_dat),
    .crs        (crs)
  );
endmodule

// File: rtl/txsup_port_chk.sv
module txsup_port_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic tx_dat,
  input logic rx_act,
  input logic full_dup,
  input logic port_lb,
  input logic line_tx_en,
  input logic line_tx_dat,
  input logic jabber,
  input logic coll,
  input logic rx_dat,
  input logic crs
);
  AST_LINE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (!line_tx_en && !line_tx_dat)); // R1
  AST_JAB_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jabber) |-> $past(tx_en)); // R2
  AST_JAB_CUTS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    jabber |-> (!line_tx_en && !line_tx_dat)); // R3
  AST_JAB_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jabber) |-> $past(!tx_en && !tx_dat)); // R4
  AST_COLL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll) |-> $past(rx_act && line_tx_en)); // R5
  AST_FD_NO_COLL: assert property (@(posedge clk) disable iff (!rst_n)
    full_dup |=> !coll); // R7
  AST_HD_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_dup && !port_lb && line_tx_en) |-> (crs && (rx_dat == tx_dat))); // R8
  AST_LB_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    port_lb |-> (!line_tx_en && (crs == tx_en))); // R10
  AST_LB_NO_COLL: assert property (@(posedge clk) disable iff (!rst_n)
    port_lb |=> !coll); // R10
endmodule

bind txsup_port txsup_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .tx_dat     (tx_dat),
  .rx_act     (rx_act),
  .full_dup   (full_dup),
  .port_lb    (port_lb),
  .line_tx_en (line_tx_en),
  .line_tx_dat(line_tx_dat),
  .jabber     (jabber),
  .coll       (coll),
  .rx_dat     (rx_dat),
  .crs        (crs)
);

// File: tb/txsup_port_tb.sv
module txsup_port_tb;
  localparam int unsigned JL = 16;
  localparam int unsigned IL = 24;

  logic clk, rst_n;
  logic tx_en, tx_dat, rx_act, rx_line_dat, full_dup, port_lb;
  logic line_tx_en, line_tx_dat, jabber, coll, rx_dat, crs;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [5:0] exp_q[$];
  logic [5:0] msk_q[$];
  string      tag_q[$];

  txsup_port #(.JAB_LIMIT(JL), .IDLE_LIMIT(IL)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_dat(tx_dat),
    .rx_act(rx_act), .rx_line_dat(rx_line_dat), .full_dup(full_dup),
    .port_lb(port_lb), .line_tx_en(line_tx_en), .line_tx_dat(line_tx_dat),
    .jabber(jabber), .coll(coll), .rx_dat(rx_dat), .crs(crs)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // bit order: [5] line_tx_en [4] line_tx_dat [3] jabber [2] coll [1] rx_dat [0] crs
  task automatic step(input bit ten, input bit tdat, input bit ract, input bit rdat,
                      input bit fd, input bit lb, input logic [5:0] e,
                      input logic [5:0] m, input string tag);
    @(negedge clk);
    tx_en = ten; tx_dat = tdat; rx_act = ract; rx_line_dat = rdat;
    full_dup = fd; port_lb = lb;
    @(posedge clk);
    #2;
    exp_q.push_back(e);
    msk_q.push_back(m);
    tag_q.push_back(tag);
  endtask

  // monitor: pops each expectation and compares against the ports
  initial begin
    forever begin
      logic [5:0] e, m, act;
      string t;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      m = msk_q.pop_front();
      t = tag_q.pop_front();
      act = {line_tx_en, line_tx_dat, jabber, coll, rx_dat, crs};
      n_cmp++;
      if ((act & m) !== (e & m)) begin
        n_fail++;
        $display("FAIL %s actual=%b expected=%b mask=%b", t, act, e, m);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  localparam logic [5:0] ALL = 6'b111111;

  initial begin
    rst_n = 1'b0;
    tx_en = 0; tx_dat = 0; rx_act = 0; rx_line_dat = 0; full_dup = 0; port_lb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    step(0,0,0,0,0,0, 6'b000000, ALL, "R11 reset state");

    // half-duplex echo and collision
    step(1,1,0,0,0,0, 6'b110011, ALL, "R8 R1 echo one");
    step(1,0,0,1,0,0, 6'b100001, ALL, "R8 echo zero, line data ignored");
    step(1,0,1,1,0,0, 6'b100101, ALL, "R5 collision set");
    step(1,0,1,1,0,0, 6'b100101, ALL, "R5 collision held");
    step(1,1,0,0,0,0, 6'b110011, ALL, "R6 clear on rx end");
    step(1,1,1,0,0,0, 6'b110111, ALL, "R5 collision set again");
    step(0,1,1,1,0,0, 6'b000011, ALL, "R6 R1 clear on tx_en toggle");
    step(0,0,0,0,0,0, 6'b000000, ALL, "R1 idle");

    // full duplex
    step(1,1,1,0,1,0, 6'b110001, ALL, "R7 no echo no coll");
    step(1,0,1,1,1,0, 6'b100011, ALL, "R7 line data through");
    step(0,0,0,0,1,0, 6'b000000, ALL, "R7 idle");

    // port loopback
    step(1,1,1,0,0,1, 6'b000011, ALL, "R10 loop one");
    step(1,0,1,1,0,1, 6'b000001, ALL, "R10 loop zero, line ignored");
    step(0,0,1,1,0,1, 6'b000000, ALL, "R10 no tx no carrier");
    step(0,0,0,0,0,0, 6'b000000, ALL, "R10 exit");

    // burst of exactly JL cycles: no jabber
    for (int i = 0; i < JL; i++)
      step(1, i[0], 0,0,0,0, 6'b100001, 6'b101001, "R2 burst at limit");
    step(0,0,0,0,0,0, 6'b000000, ALL, "R2 no jabber at limit");

    // JL+1 cycles: jabber rises on the last
    for (int i = 0; i < JL; i++)
      step(1, 1, 0,0,0,0, 6'b110011, ALL, "R2 before cut-off");
    step(1,1,0,0,0,0, 6'b001000, ALL, "R2 R3 R9 jabber cut-off");
    step(1,1,1,1,0,0, 6'b001011, ALL, "R3 R9 line data while jabbering");
    step(1,0,1,0,0,0, 6'b001001, ALL, "R3 R9 no echo, no coll");

    // release window
    for (int i = 0; i < 10; i++)
      step(0,0,0,0,0,0, 6'b001000, ALL, "R4 quiet, still jabbering");
    step(0,1,0,0,0,0, 6'b001000, ALL, "R4 data activity restarts window");
    for (int i = 0; i < IL - 1; i++)
      step(0,0,0,0,0,0, 6'b001000, ALL, "R4 quiet before release");
    step(0,0,0,0,0,0, 6'b000000, ALL, "R4 release");
    step(1,1,0,0,0,0, 6'b110011, ALL, "R1 R8 transmit after release");
    step(0,0,0,0,0,0, 6'b000000, ALL, "R1 final idle");

    wait (exp_q.size() == 0);
    #1;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule